// File: doc/BRIEF.md
# Strap-Pin PHY Configuration Controller

This block holds the per-port control registers of a multi-port 10/100 Ethernet PHY model and keeps them consistent with a set of hardware configuration pins. A global mode pin picks one of two policies. In management mode the pins only seed the registers at reset, and from then on register-write transactions own every bit. In manual mode register writes are refused, and the pin-derived registers are rebuilt from the pins on every clock.

Each port has a fiber-select pin. When it is high it overrides the global twisted-pair pins and forces that port into 100 Mb/s fiber operation with auto-negotiation off. The fiber duplex pin then sets the duplex. The block publishes each port's speed, duplex, fiber and auto-negotiation state, decoded from the register contents. Register writes arrive on a valid/ready channel. The ready signal is low only while reset is asserted and never waits on valid, so a write is taken in any cycle where both are high. Reads are a plain combinational lookup by port and address.

Top module: `phy_strap_cfg`

## Requirements
- R1: `manual_i` high selects manual mode and low selects management mode. The mode only decides whether writes are taken and whether the pins are tracked after reset.
- R2: Reset is synchronous and active high. In every port it loads register 0 and register 16 from the current pins, whatever the mode, and clears the other implemented registers.
- R3: In management mode after reset, pin changes have no effect on any register. An accepted write stores its 16-bit value, which reads back, and is reflected in the outputs, from the next cycle.
- R4: In manual mode every write is discarded. Registers 0 and 16 of each port are recomputed from the pins at every clock, so a pin change shows one cycle later.
- R5: A port whose fiber-select pin is high resolves to speed 100, fiber 1 and auto-negotiation 0, with duplex equal to `fiber_fdx_i`.
- R6: Fiber selection takes priority: when a port's fiber pin is high, the twisted-pair pins have no effect on that port.
- R7: With fiber-select low, `cfg_force_i` high and `cfg_speed_i` high, the port resolves to forced 100 Mb/s with auto-negotiation off. With `cfg_force_i` high and `cfg_speed_i` low it resolves to forced 10 Mb/s. In both forced cases duplex equals `tp_fdx_i`.
- R8: With fiber-select low and `cfg_force_i` low, the port resolves to auto-negotiation on, with speed and duplex bits 0.
- R9: Register 0 holds speed in bit 13, auto-negotiation enable in bit 12 and duplex in bit 8. Register 16 holds the fiber flag in bit 0. Every other pin-derived bit is 0.
- R10: Addresses 0 to 6 and 16 to 20 are implemented per port. Any other address reads as zero, and writes to it are ignored.
- R11: The outputs `speed_o`, `fdx_o` and `aneg_o` are bits 13, 8 and 12 of register 0, and `fiber_o` is bit 0 of register 16, for each port in the same cycle.
- R12: `wr_ready_o` is low while `rst` is high and high otherwise, and does not depend on `wr_valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, reloads from pins |
| manual_i | input | 1 | Mode pin: 1 manual, 0 management |
| cfg_force_i | input | 1 | Twisted-pair force pin: 1 forced, 0 auto-negotiation |
| cfg_speed_i | input | 1 | Twisted-pair speed pin: 1 for 100 Mb/s |
| tp_fdx_i | input | 1 | Twisted-pair forced duplex: 1 full |
| fiber_fdx_i | input | 1 | Fiber duplex: 1 full |
| fiber_sel_i | input | NPORTS | Per-port fiber select |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write channel ready |
| wr_port_i | input | PW | Write target port |
| wr_addr_i | input | 5 | Write register address |
| wr_data_i | input | 16 | Write data |
| rd_port_i | input | PW | Read port |
| rd_addr_i | input | 5 | Read register address |
| rd_data_o | output | 16 | Read data (combinational) |
| speed_o | output | NPORTS | Resolved speed, 1 for 100 Mb/s |
| fdx_o | output | NPORTS | Resolved duplex, 1 for full |
| fiber_o | output | NPORTS | Fiber operation |
| aneg_o | output | NPORTS | Auto-negotiation enabled |

## Verification
The properties assume that the strap pins and the write channel change only between clock edges. They also take the mode pin as meaningful only outside reset. The pin-resolution properties are conditioned on manual mode in the sampled cycle, and the stability property on management mode with no accepted write. The bench drives every input half a cycle away from the sampling edge, and it mixes mode changes, writes to implemented and unimplemented addresses, and pin toggles. This keeps every property's premise reachable without breaking those assumptions.

// File: rtl/phy_strap_pkg.sv
package phy_strap_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 5;
  localparam int LO_CNT  = 7;   // addresses 0..6
  localparam int HI_BASE = 16;  // addresses 16..20
  localparam int HI_CNT  = 5;
  localparam int NSLOT   = LO_CNT + HI_CNT;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int CTL_SLOT = 0;
  localparam int CFG_SLOT = LO_CNT;
  localparam int BIT_SPEED = 13;
  localparam int BIT_ANEG  = 12;
  localparam int BIT_FDX   = 8;
  localparam int BIT_FIBER = 0;

  typedef struct packed {
    logic speed;
    logic aneg;
    logic fdx;
    logic fiber;
  } port_mode_t;

  function automatic logic addr_valid(input logic [ADDR_W-1:0] a);
    return (int'(a) < LO_CNT) ||
           (int'(a) >= HI_BASE && int'(a) < HI_BASE + HI_CNT);
  endfunction

  function automatic logic [SLOT_W-1:0] addr_slot(input logic [ADDR_W-1:0] a);
    if (int'(a) < LO_CNT) return SLOT_W'(a);
    return SLOT_W'(int'(a) - HI_BASE + LO_CNT);
  endfunction
endpackage

// File: rtl/phy_strap_resolve.sv
module phy_strap_resolve
  import phy_strap_pkg::*;
(
  input  logic fiber_sel_i,
  input  logic fiber_fdx_i,
  input  logic cfg_force_i,
  input  logic cfg_speed_i,
  input  logic tp_fdx_i,
  output logic [REG_W-1:0] ctl_word_o,
  output logic [REG_W-1:0] cfg_word_o
);
  port_mode_t mode;

  always_comb begin
    mode = '0;
    if (fiber_sel_i) begin
      mode.fiber = 1'b1;
      mode.speed = 1'b1;
      mode.fdx   = fiber_fdx_i;
    end else if (cfg_force_i) begin
      mode.speed = cfg_speed_i;
      mode.fdx   = tp_fdx_i;
    end else begin
      mode.aneg  = 1'b1;
    end
  end

  always_comb begin
    ctl_word_o = '0;
    ctl_word_o[BIT_SPEED] = mode.speed;
    ctl_word_o[BIT_ANEG]  = mode.aneg;
    ctl_word_o[BIT_FDX]   = mode.fdx;
    cfg_word_o = '0;
    cfg_word_o[BIT_FIBER] = mode.fiber;
  end
endmodule

// File: rtl/phy_strap_port_regs.sv
module phy_strap_port_regs
  import phy_strap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic track_i,
  input  logic [REG_W-1:0] ctl_word_i,
  input  logic [REG_W-1:0] cfg_word_i,
  input  logic wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [NSLOT-1:0][REG_W-1:0] regs_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam bit IS_CTL = (s == CTL_SLOT);
    localparam bit IS_CFG = (s == CFG_SLOT);
    if (IS_CTL || IS_CFG) begin : g_pin
      logic [REG_W-1:0] pin_word;
      assign pin_word = IS_CTL ? ctl_word_i : cfg_word_i;
      always_ff @(posedge clk) begin
        if (rst || track_i)
          regs_o[s] <= pin_word;
        else if (wr_en_i && wr_slot_i == SLOT_W'(s))
          regs_o[s] <= wr_data_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)
          regs_o[s] <= '0;
        else if (wr_en_i && wr_slot_i == SLOT_W'(s))
          regs_o[s] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/phy_strap_cfg.sv
module phy_strap_cfg
  import phy_strap_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
)(
  input  logic clk,
  input  logic rst,
  input  logic manual_i,
  input  logic cfg_force_i,
  input  logic cfg_speed_i,
  input  logic tp_fdx_i,
  input  logic fiber_fdx_i,
  input  logic [NPORTS-1:0] fiber_sel_i,
  input  logic wr_valid_i,
  output logic wr_ready_o,
  input  logic [PW-1:0] wr_port_i,
  input  logic [4:0] wr_addr_i,
  input  logic [15:0] wr_data_i,
  input  logic [PW-1:0] rd_port_i,
  input  logic [4:0] rd_addr_i,
  output logic [15:0] rd_data_o,
  output logic [NPORTS-1:0] speed_o,
  output logic [NPORTS-1:0] fdx_o,
  output logic [NPORTS-1:0] fiber_o,
  output logic [NPORTS-1:0] aneg_o
);
  logic [NPORTS-1:0][NSLOT-1:0][REG_W-1:0] regs;
  logic wr_take;
  logic [SLOT_W-1:0] wr_slot;

  assign wr_ready_o = !rst;
  assign wr_take = wr_valid_i && wr_ready_o && !manual_i && addr_valid(wr_addr_i);
  assign wr_slot = addr_slot(wr_addr_i);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [REG_W-1:0] ctl_word, cfg_word;

    phy_strap_resolve u_res (
      .fiber_sel_i(fiber_sel_i[p]),
      .fiber_fdx_i(fiber_fdx_i),
      .cfg_force_i(cfg_force_i),
      .cfg_speed_i(cfg_speed_i),
      .tp_fdx_i   (tp_fdx_i),
      .ctl_word_o (ctl_word),
      .cfg_word_o (cfg_word)
    );

    phy_strap_port_regs u_regs (
      .clk       (clk),
      .rst       (rst),
      .track_i   (manual_i),
      .ctl_word_i(ctl_word),
      .cfg_word_i(cfg_word),
      .wr_en_i   (wr_take && wr_port_i == PW'(p)),
      .wr_slot_i (wr_slot),
      .wr_data_i (wr_data_i),
      .regs_o    (regs[p])
    );

    assign speed_o[p] = regs[p][CTL_SLOT][BIT_SPEED];
    assign aneg_o[p]  = regs[p][CTL_SLOT][BIT_ANEG];
    assign fdx_o[p]   = regs[p][CTL_SLOT][BIT_FDX];
    assign fiber_o[p] = regs[p][CFG_SLOT][BIT_FIBER];
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_valid(rd_addr_i) && int'(rd_port_i) < NPORTS)
      rd_data_o = regs[rd_port_i][addr_slot(rd_addr_i)];
  end
endmodule

// File: rtl/phy_strap_cfg_chk.sv
module phy_strap_cfg_chk
  import phy_strap_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PW = 2
)(
  input logic clk,
  input logic rst,
  input logic manual_i,
  input logic cfg_force_i,
  input logic cfg_speed_i,
  input logic fiber_fdx_i,
  input logic [NPORTS-1:0] fiber_sel_i,
  input logic wr_valid_i,
  input logic wr_ready_o,
  input logic [4:0] rd_addr_i,
  input logic [15:0] rd_data_o,
  input logic [NPORTS-1:0] speed_o,
  input logic [NPORTS-1:0] fdx_o,
  input logic [NPORTS-1:0] fiber_o,
  input logic [NPORTS-1:0] aneg_o
);
  // R3
  hold_in_mgmt_chk: assert property (@(posedge clk) disable iff (rst)
    (!manual_i && !(wr_valid_i && wr_ready_o)) |=>
      ($stable(speed_o) && $stable(fdx_o) && $stable(fiber_o) && $stable(aneg_o)));

  // R10
  unimpl_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_valid(rd_addr_i) |-> rd_data_o == '0);

  // R12
  ready_out_of_reset_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ready_o);

  for (genvar p = 0; p < NPORTS; p++) begin : g_p
    // R5
    fiber_force_chk: assert property (@(posedge clk) disable iff (rst)
      (manual_i && fiber_sel_i[p]) |=>
        (fiber_o[p] && speed_o[p] && !aneg_o[p] && fdx_o[p] == $past(fiber_fdx_i)));
    // R7
    tp_100_chk: assert property (@(posedge clk) disable iff (rst)
      (manual_i && !fiber_sel_i[p] && cfg_force_i && cfg_speed_i) |=>
        (speed_o[p] && !aneg_o[p] && !fiber_o[p]));
    // R8
    tp_aneg_chk: assert property (@(posedge clk) disable iff (rst)
      (manual_i && !fiber_sel_i[p] && !cfg_force_i) |=>
        (aneg_o[p] && !speed_o[p] && !fdx_o[p]));
  end
endmodule

bind phy_strap_cfg phy_strap_cfg_chk #(.NPORTS(NPORTS), .PW(PW)) chk_i (.*);

// File: tb/phy_strap_cfg_tb_top.sv
module phy_strap_cfg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic manual_i = 1'b0, cfg_force_i = 1'b0, cfg_speed_i = 1'b0;
  logic tp_fdx_i = 1'b0, fiber_fdx_i = 1'b0;
  logic [NP-1:0] fiber_sel_i = '0;
  logic wr_valid_i = 1'b0;
  logic wr_ready_o;
  logic [PW-1:0] wr_port_i = '0, rd_port_i = '0;
  logic [4:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [15:0] wr_data_i = '0, rd_data_o;
  logic [NP-1:0] speed_o, fdx_o, fiber_o, aneg_o;

  int checks = 0, errors = 0;
  bit started = 1'b0;
  logic [15:0] mreg [NP][32];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_strap_cfg #(.NPORTS(NP)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit impl(input int a);
    return (a <= 6) || (a >= 16 && a <= 20);
  endfunction

  function automatic logic [15:0] exp_ctl(input int p);
    logic [15:0] w = 16'h0;
    if (fiber_sel_i[p]) begin w[13] = 1; w[8] = fiber_fdx_i; end
    else if (cfg_force_i) begin w[13] = cfg_speed_i; w[8] = tp_fdx_i; end
    else w[12] = 1;
    return w;
  endfunction

  // reference model, updated at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) begin
        for (int a = 0; a < 32; a++) mreg[p][a] = 16'h0;
        mreg[p][0] = exp_ctl(p);
        mreg[p][16] = {15'h0, fiber_sel_i[p]};
      end
      started = 1'b1;
    end else begin
      if (!manual_i && wr_valid_i && impl(int'(wr_addr_i)))
        mreg[wr_port_i][wr_addr_i] = wr_data_i;
      if (manual_i)
        for (int p = 0; p < NP; p++) begin
          mreg[p][0] = exp_ctl(p);
          mreg[p][16] = {15'h0, fiber_sel_i[p]};
        end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (started) begin
    for (int p = 0; p < NP; p++) begin
      chk(speed_o[p] == mreg[p][0][13], "R11 speed", 16'(speed_o[p]), 16'(mreg[p][0][13]));
      chk(fdx_o[p]   == mreg[p][0][8],  "R11 duplex", 16'(fdx_o[p]), 16'(mreg[p][0][8]));
      chk(aneg_o[p]  == mreg[p][0][12], "R11 aneg", 16'(aneg_o[p]), 16'(mreg[p][0][12]));
      chk(fiber_o[p] == mreg[p][16][0], "R11 fiber", 16'(fiber_o[p]), 16'(mreg[p][16][0]));
    end
    chk(rd_data_o == (impl(int'(rd_addr_i)) ? mreg[rd_port_i][rd_addr_i] : 16'h0),
        "R10 read", rd_data_o, impl(int'(rd_addr_i)) ? mreg[rd_port_i][rd_addr_i] : 16'h0);
    chk(wr_ready_o == !rst, "R12 ready", 16'(wr_ready_o), 16'(!rst));
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic rd(input int p, input int a, output logic [15:0] d);
    rd_port_i = PW'(p); rd_addr_i = 5'(a); #1; d = rd_data_o;
  endtask

  task automatic wr(input int p, input int a, input logic [15:0] d);
    wr_valid_i = 1; wr_port_i = PW'(p); wr_addr_i = 5'(a); wr_data_i = d;
    step();
    wr_valid_i = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [15:0] d;
    // reset in management mode, all fiber
    fiber_sel_i = 4'b1111; fiber_fdx_i = 1;
    step(3);
    chk(wr_ready_o == 0, "R12 low in reset", 16'(wr_ready_o), 16'h0);
    rst = 0; step();
    rd(2, 0, d);  chk(d == 16'h2100, "R2 reset ctl", d, 16'h2100);
    rd(2, 16, d); chk(d == 16'h0001, "R2 reset cfg", d, 16'h0001);
    rd(1, 3, d);  chk(d == 16'h0000, "R2 other clear", d, 16'h0000);
    // management mode: pins have no effect
    fiber_sel_i = 4'b0000; cfg_force_i = 0; step(2);
    chk(fiber_o == 4'b1111 && aneg_o == 4'b0000, "R3 pins ignored", {8'h0, fiber_o, aneg_o}, 16'h00F0);
    wr(3, 0, 16'h0000); step();
    chk(speed_o[3] == 0 && fiber_o[3] == 1, "R11 write ctl", 16'(speed_o[3]), 16'h0);
    wr(1, 5, 16'hBEEF);
    rd(1, 5, d); chk(d == 16'hBEEF, "R3 write readback", d, 16'hBEEF);
    wr(1, 9, 16'h1234);
    rd(1, 9, d); chk(d == 16'h0000, "R10 unimpl write", d, 16'h0000);
    wr(0, 20, 16'h5A5A);
    rd(0, 20, d); chk(d == 16'h5A5A, "R10 top address", d, 16'h5A5A);
    // manual mode: pins tracked, writes blocked
    manual_i = 1; fiber_sel_i = 4'b0001; fiber_fdx_i = 1;
    cfg_force_i = 1; cfg_speed_i = 1; tp_fdx_i = 0; step();
    chk(fiber_o[0] && speed_o[0] && fdx_o[0] && !aneg_o[0], "R5 fiber port", {12'h0, fiber_o[0], speed_o[0], fdx_o[0], aneg_o[0]}, 16'h000E);
    chk(speed_o[1] && !fdx_o[1] && !aneg_o[1] && !fiber_o[1], "R7 100 forced", {14'h0, speed_o[1], fdx_o[1]}, 16'h0002);
    chk(fiber_o[3] == 0, "R1 manual tracks", 16'(fiber_o[3]), 16'h0);
    cfg_speed_i = 0; tp_fdx_i = 1; step();
    chk(!speed_o[1] && fdx_o[1], "R7 10 forced", {14'h0, speed_o[1], fdx_o[1]}, 16'h0001);
    chk(speed_o[0] && fdx_o[0], "R6 fiber priority", {14'h0, speed_o[0], fdx_o[0]}, 16'h0003);
    cfg_force_i = 0; step();
    chk(aneg_o[2] && !speed_o[2] && !fdx_o[2], "R8 aneg", {13'h0, aneg_o[2], speed_o[2], fdx_o[2]}, 16'h0004);
    rd(2, 0, d); chk(d == 16'h1000, "R9 aneg word", d, 16'h1000);
    rd(0, 0, d); chk(d == 16'h2100, "R9 fiber word", d, 16'h2100);
    wr(2, 1, 16'hFFFF);
    rd(2, 1, d); chk(d == 16'h0000, "R4 write blocked", d, 16'h0000);
    wr(2, 0, 16'h0000);
    chk(aneg_o[2] == 1, "R4 ctl write blocked", 16'(aneg_o[2]), 16'h1);
    // reset in manual mode reloads and clears
    rst = 1; step(2); rst = 0; step();
    rd(0, 20, d); chk(d == 16'h0000, "R2 reload clears", d, 16'h0000);
    // random phase checked against the model each cycle
    for (int i = 0; i < 600; i++) begin
      manual_i = ($urandom_range(0, 3) == 0);
      cfg_force_i = 1'($urandom); cfg_speed_i = 1'($urandom);
      tp_fdx_i = 1'($urandom); fiber_fdx_i = 1'($urandom);
      fiber_sel_i = 4'($urandom);
      wr_valid_i = 1'($urandom); wr_port_i = 2'($urandom);
      wr_addr_i = 5'($urandom); wr_data_i = 16'($urandom);
      rd_port_i = 2'($urandom); rd_addr_i = 5'($urandom);
      rst = ($urandom_range(0, 40) == 0);
      step();
    end
    rst = 0; wr_valid_i = 0; step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule